// File: doc/BRIEF.md
# Serial Controller Interrupt Unit

This block gathers the interrupt conditions of a FIFO-based serial controller and turns them into one interrupt line. The transmit and receive paths report their current FIFO fill levels and a few single-cycle events: a data push, a data pop, the end of a received frame and a bus contention indication. From these the unit derives six interrupt sources. Four of them are error conditions: transmit overflow, receive underflow, receive overflow and contention. These are latched and stay set until software reads a dedicated clear register. The other two are live level comparisons against programmable thresholds and cannot be cleared. One of them is transmit-empty, asserted while the transmit level is at or below its threshold. The other is receive-full, asserted while the receive level is above its threshold.

Software reaches the unit over a simple word-addressed register port. Through it, software sets the source enables, sees the flags before and after masking, programs both thresholds and clears the latched errors. The interrupt output is a registered OR of the enabled flags, so it is glitch-free and follows the masked status by one clock.

Top module: `serial_irq_unit`

## Requirements
- R1: After reset, all latched flags, the enable mask, both thresholds and `irq` are zero. Raw status then shows only bit 0 if `tx_level` is 0.
- R2: Each latched flag is set in the cycle after its condition is present at a clock edge:
  - bit 1 (transmit overflow): `tx_push` with `tx_level` equal to FIFO_DEPTH.
  - bit 2 (receive underflow): `rx_pop` with `rx_level` equal to 0.
  - bit 3 (receive overflow): `rx_frame_done` with `rx_level` equal to FIFO_DEPTH.
  - bit 5 (contention): `contend_evt`.
- R3: A latched flag stays set, through idle cycles and any number of other events, until it is cleared as R4 describes.
- R4: A read of a clear register returns the flag's value before the clear in bit 0 and clears that flag:
  - address 7 clears bit 1.
  - address 8 clears bit 2.
  - address 9 clears bit 3.
  - address 10 clears bit 5.

  If the flag's set condition occurs in the same cycle as the read, the flag stays set.
- R5: Raw bit 0 (transmit-empty) is 1 exactly while `tx_level` is at or below the transmit threshold at address 5. It follows the level with no latency, and no register access clears it. A threshold write larger than FIFO_DEPTH stores FIFO_DEPTH.
- R6: Raw bit 4 (receive-full) is 1 exactly while `rx_level` is greater than the receive threshold at address 6, which saturates the same way.
- R7: The enable mask is written in three ways:
  - address 0 is a read/write mask in which 1 enables a source.
  - a write to address 1 disables every source whose data bit is 1.
  - a write to address 2 enables every source whose data bit is 1.
- R8: Address 3 reads the raw flags ANDed with the mask, and address 4 reads the raw flags. Both use only bits 5:0, and bits above them read 0. `irq` is 1 in the cycle after one in which the masked status is nonzero, and 0 otherwise.
- R9: Writes to addresses 3, 4, 7 to 10 and to undefined addresses change no state. Reads of undefined addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives read side effects) |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from address |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| rx_level | input | LVL_W | Receive FIFO fill level |
| tx_push | input | 1 | Data word written toward transmit FIFO |
| rx_pop | input | 1 | Data word read from receive FIFO |
| rx_frame_done | input | 1 | A received frame completed this cycle |
| contend_evt | input | 1 | Multi-master contention detected |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the unit with FIFO_DEPTH of 4 and DATA_W of 16, so the level ports are three bits wide. With that depth, every level from empty to full can be driven directly. The threshold extremes can also be reached: a threshold equal to the depth, and a write far above the depth that must saturate. Both overflow conditions can be produced without long fill sequences. A behavioural model is compared against `irq` and every read on every clock. Directed reads check the R2 set conditions next to their near misses, one level below full or above empty. They also cover the same-cycle set-and-clear case of R4.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam int NSRC = 6;

  // source bit positions, decoded by the status and clear registers
  localparam int B_TXE = 0;
  localparam int B_TXO = 1;
  localparam int B_RXU = 2;
  localparam int B_RXO = 3;
  localparam int B_RXF = 4;
  localparam int B_CON = 5;

  // which sources latch (1) and which are live levels (0)
  localparam logic [NSRC-1:0] STICKY_MASK = 6'b101110;

  localparam logic [3:0] A_MASK    = 4'd0;
  localparam logic [3:0] A_MDIS    = 4'd1;
  localparam logic [3:0] A_MEN     = 4'd2;
  localparam logic [3:0] A_STAT    = 4'd3;
  localparam logic [3:0] A_RAW     = 4'd4;
  localparam logic [3:0] A_TXTHR   = 4'd5;
  localparam logic [3:0] A_RXTHR   = 4'd6;
  localparam logic [3:0] A_CLR_TXO = 4'd7;
  localparam logic [3:0] A_CLR_RXU = 4'd8;
  localparam logic [3:0] A_CLR_RXO = 4'd9;
  localparam logic [3:0] A_CLR_CON = 4'd10;

  // level at or below threshold
  function automatic logic lvl_le(input logic [31:0] lvl, input logic [31:0] thr);
    return lvl <= thr;
  endfunction

  // clamp a written threshold to the FIFO depth
  function automatic logic [31:0] sat_level(input logic [31:0] v, input logic [31:0] depth);
    return (v > depth) ? depth : v;
  endfunction

  // map a clear-register address to the source bit it clears
  function automatic logic [NSRC-1:0] clr_decode(input logic [3:0] a);
    logic [NSRC-1:0] r;
    r = '0;
    case (a)
      A_CLR_TXO: r[B_TXO] = 1'b1;
      A_CLR_RXU: r[B_RXU] = 1'b1;
      A_CLR_RXO: r[B_RXO] = 1'b1;
      A_CLR_CON: r[B_CON] = 1'b1;
      default:   r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/sirq_flags.sv
module sirq_flags
  import sirq_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int LVL_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_thr,
  input  logic [LVL_W-1:0] rx_thr,
  input  logic             tx_push,
  input  logic             rx_pop,
  input  logic             rx_frame_done,
  input  logic             contend_evt,
  input  logic [NSRC-1:0]  clr_pulse,
  output logic [NSRC-1:0]  set_evt,
  output logic [NSRC-1:0]  raw
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);

  logic [NSRC-1:0] live;
  logic [NSRC-1:0] flag_q;

  always_comb begin
    set_evt        = '0;
    set_evt[B_TXO] = tx_push && (tx_level == FULL_LVL);
    set_evt[B_RXU] = rx_pop && (rx_level == '0);
    set_evt[B_RXO] = rx_frame_done && (rx_level == FULL_LVL);
    set_evt[B_CON] = contend_evt;

    live        = '0;
    live[B_TXE] = lvl_le(32'(tx_level), 32'(tx_thr));
    live[B_RXF] = !lvl_le(32'(rx_level), 32'(rx_thr));
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n)
        flag_q[i] <= 1'b0;
      else if (STICKY_MASK[i]) begin
        if (set_evt[i])
          flag_q[i] <= 1'b1;
        else if (clr_pulse[i])
          flag_q[i] <= 1'b0;
      end
    end
    assign raw[i] = STICKY_MASK[i] ? flag_q[i] : live[i];
  end
endmodule

// File: rtl/sirq_regs.sv
module sirq_regs
  import sirq_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int LVL_W      = 4,
  parameter int DATA_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [3:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [NSRC-1:0]   raw,
  output logic [NSRC-1:0]   mask,
  output logic [LVL_W-1:0]  tx_thr,
  output logic [LVL_W-1:0]  rx_thr,
  output logic [NSRC-1:0]   clr_pulse,
  output logic [DATA_W-1:0] reg_rdata
);
  logic [NSRC-1:0]  wbits;
  logic [LVL_W-1:0] wthr;

  assign wbits     = reg_wdata[NSRC-1:0];
  assign wthr      = LVL_W'(sat_level(32'(reg_wdata), 32'(FIFO_DEPTH)));
  assign clr_pulse = reg_rd ? clr_decode(reg_addr) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask   <= '0;
      tx_thr <= '0;
      rx_thr <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_MASK:  mask   <= wbits;
        A_MDIS:  mask   <= mask & ~wbits;
        A_MEN:   mask   <= mask | wbits;
        A_TXTHR: tx_thr <= wthr;
        A_RXTHR: rx_thr <= wthr;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      A_MASK:    reg_rdata = DATA_W'(mask);
      A_STAT:    reg_rdata = DATA_W'(raw & mask);
      A_RAW:     reg_rdata = DATA_W'(raw);
      A_TXTHR:   reg_rdata = DATA_W'(tx_thr);
      A_RXTHR:   reg_rdata = DATA_W'(rx_thr);
      A_CLR_TXO: reg_rdata = DATA_W'(raw[B_TXO]);
      A_CLR_RXU: reg_rdata = DATA_W'(raw[B_RXU]);
      A_CLR_RXO: reg_rdata = DATA_W'(raw[B_RXO]);
      A_CLR_CON: reg_rdata = DATA_W'(raw[B_CON]);
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/serial_irq_unit.sv
module serial_irq_unit
  import sirq_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int DATA_W     = 16,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [3:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              tx_push,
  input  logic              rx_pop,
  input  logic              rx_frame_done,
  input  logic              contend_evt,
  output logic              irq
);
  logic [NSRC-1:0]  raw;
  logic [NSRC-1:0]  mask;
  logic [NSRC-1:0]  set_evt;
  logic [NSRC-1:0]  clr_pulse;
  logic [LVL_W-1:0] tx_thr;
  logic [LVL_W-1:0] rx_thr;
  logic [NSRC-1:0]  masked;

  sirq_regs #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .raw(raw), .mask(mask), .tx_thr(tx_thr), .rx_thr(rx_thr),
    .clr_pulse(clr_pulse), .reg_rdata(reg_rdata)
  );

  sirq_flags #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .tx_level(tx_level), .rx_level(rx_level), .tx_thr(tx_thr), .rx_thr(rx_thr),
    .tx_push(tx_push), .rx_pop(rx_pop), .rx_frame_done(rx_frame_done),
    .contend_evt(contend_evt), .clr_pulse(clr_pulse),
    .set_evt(set_evt), .raw(raw)
  );

  assign masked = raw & mask;

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |masked;
  end
endmodule

// File: rtl/sirq_chk.sv
module sirq_chk
  import sirq_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] tx_level,
  input logic [LVL_W-1:0] rx_level,
  input logic             irq,
  input logic [NSRC-1:0]  raw,
  input logic [NSRC-1:0]  mask,
  input logic [NSRC-1:0]  set_evt,
  input logic [NSRC-1:0]  clr_pulse
);
  p_set_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_evt) |=> ((raw & $past(set_evt)) == $past(set_evt)));

  p_sticky_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(raw & STICKY_MASK & ~clr_pulse)) |=>
      ((raw & $past(raw & STICKY_MASK & ~clr_pulse)) == $past(raw & STICKY_MASK & ~clr_pulse)));

  p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_pulse & ~set_evt & STICKY_MASK)) |=>
      ((raw & $past(clr_pulse & ~set_evt & STICKY_MASK)) == '0));

  p_empty_tx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == '0) |-> raw[B_TXE]);

  p_empty_rx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == '0) |-> !raw[B_RXF]);

  p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(raw & mask)) |=> irq);

  p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(raw & mask)) |=> !irq);
endmodule

bind serial_irq_unit sirq_chk #(.LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .rx_level(rx_level),
  .irq(irq), .raw(raw), .mask(mask), .set_evt(set_evt), .clr_pulse(clr_pulse)
);

// File: tb/serial_irq_unit_tb_top.sv
module serial_irq_unit_tb_top;
  localparam int DEPTH = 4;
  localparam int DW    = 16;
  localparam int LW    = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [LW-1:0] tx_level = '0, rx_level = '0;
  logic          tx_push = 1'b0, rx_pop = 1'b0, rx_frame_done = 1'b0, contend_evt = 1'b0;
  logic          irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  serial_irq_unit #(.FIFO_DEPTH(DEPTH), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_level(tx_level), .rx_level(rx_level),
    .tx_push(tx_push), .rx_pop(rx_pop), .rx_frame_done(rx_frame_done),
    .contend_evt(contend_evt), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  bit [5:0] m_flag, m_mask;
  int       m_txthr, m_rxthr;
  bit       m_irq;

  function automatic bit [5:0] m_raw();
    bit [5:0] r;
    r    = m_flag;
    r[0] = (int'(tx_level) <= m_txthr);
    r[4] = (int'(rx_level) > m_rxthr);
    return r;
  endfunction

  function automatic int m_read(input int a);
    bit [5:0] r;
    r = m_raw();
    case (a)
      0: return int'(m_mask);
      3: return int'(r & m_mask);
      4: return int'(r);
      5: return m_txthr;
      6: return m_rxthr;
      7: return int'(m_flag[1]);
      8: return int'(m_flag[2]);
      9: return int'(m_flag[3]);
      10: return int'(m_flag[5]);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_flag = '0; m_mask = '0; m_txthr = 0; m_rxthr = 0; m_irq = 1'b0;
    end else begin
      bit [5:0] r, nf, st;
      int wv;
      r  = m_raw();
      m_irq = |(r & m_mask);
      st = '0;
      st[1] = tx_push && (int'(tx_level) == DEPTH);
      st[2] = rx_pop && (rx_level == 0);
      st[3] = rx_frame_done && (int'(rx_level) == DEPTH);
      st[5] = contend_evt;
      nf = m_flag;
      if (reg_rd) begin
        case (int'(reg_addr))
          7: nf[1] = 1'b0;
          8: nf[2] = 1'b0;
          9: nf[3] = 1'b0;
          10: nf[5] = 1'b0;
          default: ;
        endcase
      end
      nf = nf | st;
      m_flag = nf;
      if (reg_wr) begin
        wv = int'(reg_wdata);
        case (int'(reg_addr))
          0: m_mask = reg_wdata[5:0];
          1: m_mask = m_mask & ~reg_wdata[5:0];
          2: m_mask = m_mask | reg_wdata[5:0];
          5: m_txthr = (wv > DEPTH) ? DEPTH : wv;
          6: m_rxthr = (wv > DEPTH) ? DEPTH : wv;
          default: ;
        endcase
      end
    end
  end

  // compared every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (irq !== m_irq) begin
        fails++;
        $display("FAIL R8 model irq: actual %0b expected %0b", irq, m_irq);
      end
      if (reg_rd) begin
        checks++;
        if (int'(reg_rdata) != m_read(int'(reg_addr))) begin
          fails++;
          $display("FAIL R4/R8 model read addr %0d: actual %0h expected %0h",
                   reg_addr, reg_rdata, m_read(int'(reg_addr)));
        end
      end
    end
  end

  // ---------------- stimulus helpers (entered at posedge+2) ----------------
  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr(input int a, input int v);
    reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = DW'(v);
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd_exp(input int a, input int exp, input string tag);
    reg_rd = 1'b1; reg_addr = 4'(a);
    @(negedge clk);
    checks++;
    if (int'(reg_rdata) != exp) begin
      fails++;
      $display("FAIL %s read addr %0d: actual %0h expected %0h", tag, a, reg_rdata, exp);
    end
    step();
    reg_rd = 1'b0;
  endtask

  task automatic irq_exp(input bit exp, input string tag);
    @(negedge clk);
    checks++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s irq: actual %0b expected %0b", tag, irq, exp);
    end
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 reset state
    rd_exp(4, 'h01, "R1");
    rd_exp(0, 0, "R1");
    rd_exp(5, 0, "R1");
    irq_exp(1'b0, "R1");
    // R5 transmit-empty threshold
    wr(5, 2);
    tx_level = 3'd2; rd_exp(4, 'h01, "R5");
    tx_level = 3'd3; rd_exp(4, 'h00, "R5");
    wr(5, 4);        rd_exp(4, 'h01, "R5");
    wr(5, 2);        rd_exp(4, 'h00, "R5");
    // R6 receive-full threshold
    wr(6, 1);
    rx_level = 3'd1; rd_exp(4, 'h00, "R6");
    rx_level = 3'd2; rd_exp(4, 'h10, "R6");
    rx_level = 3'd0;
    // R2 transmit overflow, near miss then hit
    tx_push = 1'b1; step(); tx_push = 1'b0;
    rd_exp(4, 'h00, "R2");
    tx_level = 3'd4; tx_push = 1'b1; step(); tx_push = 1'b0; tx_level = 3'd3;
    rd_exp(4, 'h02, "R2");
    // R4 clear by read
    rd_exp(7, 1, "R4");
    rd_exp(4, 'h00, "R4");
    rd_exp(7, 0, "R4");
    // R2 receive underflow, overflow, contention
    rx_level = 3'd1; rx_pop = 1'b1; step(); rx_pop = 1'b0;
    rd_exp(4, 'h00, "R2");
    rx_level = 3'd0; rx_pop = 1'b1; step(); rx_pop = 1'b0;
    rd_exp(4, 'h04, "R2");
    rx_level = 3'd4; rx_frame_done = 1'b1; step(); rx_frame_done = 1'b0;
    rd_exp(4, 'h1C, "R2");
    contend_evt = 1'b1; step(); contend_evt = 1'b0;
    rd_exp(4, 'h3C, "R2");
    rx_level = 3'd0;
    rd_exp(4, 'h2C, "R6");
    // R3 sticky across idle cycles
    repeat (5) step();
    rd_exp(4, 'h2C, "R3");
    // R9 ignored writes and undefined addresses
    wr(3, 'hFFFF); wr(4, 'hFFFF); wr(9, 'hFFFF); wr(12, 'hFFFF);
    rd_exp(4, 'h2C, "R9");
    rd_exp(0, 0, "R9");
    rd_exp(12, 0, "R9");
    rd_exp(6, 1, "R9");
    // R5 threshold saturation
    wr(5, 'h00FF); rd_exp(5, 4, "R5");
    wr(5, 2);      rd_exp(5, 2, "R5");
    // R7 / R8 mask and registered irq
    wr(0, 'h3F);
    irq_exp(1'b0, "R8");
    irq_exp(1'b1, "R8");
    rd_exp(3, 'h2C, "R8");
    rd_exp(0, 'h3F, "R7");
    wr(1, 'h3F);
    rd_exp(0, 0, "R7");
    rd_exp(3, 0, "R7");
    irq_exp(1'b0, "R8");
    wr(2, 'h08);
    rd_exp(3, 'h08, "R7");
    irq_exp(1'b1, "R8");
    rd_exp(9, 1, "R4");
    irq_exp(1'b1, "R8");
    irq_exp(1'b0, "R8");
    // R4 set in the same cycle as the clearing read
    contend_evt = 1'b1; rd_exp(10, 1, "R4"); contend_evt = 1'b0;
    rd_exp(4, 'h24, "R4");
    rd_exp(10, 1, "R4");
    rd_exp(10, 0, "R4");
    rd_exp(8, 1, "R4");
    rd_exp(4, 'h00, "R4");
    // R5 live bit not cleared by any clear read
    tx_level = 3'd0;
    rd_exp(7, 0, "R5");
    rd_exp(4, 'h01, "R5");
    repeat (2) step();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule